// File: doc/BRIEF.md
# General-Purpose Pin Register Set

This block is a memory-mapped controller for a group of general-purpose pins, 32 by default. A simple single-cycle register bus reaches it: a byte address, a write enable, write data and combinational read data. For each pin the block holds a direction bit and an output latch bit. It drives the pad's output enable and output value from those bits. The raw level of every pad passes through a clocked synchronizer and can then be read back.

Software can change the output latch without a read-modify-write sequence. It writes a mask to a set register, which forces the marked bits high, or to a clear register, which forces them low. All other bits keep their value. The whole latch can also be loaded through the output-data word. Input readback lags the pads by the synchronizer depth, so a read taken right after a change still returns the old level.

Top module: `gpio_regbank`

## Requirements
- R1: After reset every direction bit is 1 and every latch bit is 0. So `pin_oe` is all zeros, `pin_out` is all zeros, and reading offset 0x00 returns all ones.
- R2: Offset 0x00 is the direction word and is read/write. A direction bit of 1 makes its pin an input (`pin_oe` bit 0). A bit of 0 makes it an output (`pin_oe` bit 1). `pin_oe` follows the edge that takes the write.
- R3: A write to offset 0x04 loads the whole output latch. `pin_out` shows the new value after the edge that takes the write, and a read of 0x04 returns it.
- R4: A write to offset 0x08 sets each latch bit whose mask bit is 1. Latch bits whose mask bit is 0 keep their value. A mask of zero changes nothing.
- R5: A write to offset 0x0C clears each latch bit whose mask bit is 1. Latch bits whose mask bit is 0 keep their value.
- R6: Reads of offsets 0x08 and 0x0C return the current output latch.
- R7: Offset 0x10 returns the level of `pin_in` taken through a two-flop synchronizer, whatever the direction bits are. A change on `pin_in` is not visible after one rising edge but is visible after two. Writes to 0x10 change nothing.
- R8: Any other offset, including an address whose two low bits are not zero, reads as zero. A write to such an address changes neither the direction word nor the latch.
- R9: `pin_out` always shows the latch, including for pins set as inputs. Changing a direction bit does not change the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registers and the synchronizer |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (5) | Byte address of the register word |
| bus_we | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | PIN_W (32) | Write data or mask |
| bus_rdata | output | PIN_W (32) | Combinational read data for `bus_addr` |
| pin_in | input | PIN_W (32) | Raw pad levels |
| pin_oe | output | PIN_W (32) | Per-pin output enable, 1 = driving |
| pin_out | output | PIN_W (32) | Per-pin output value from the latch |

## Verification
The bench builds the block with its defaults: 32 pins, a 5-bit address and a synchronizer depth of 2. With these values every one of the eight word slots, including the three unused ones, is reachable, and misaligned addresses can be driven as well. The depth of 2 makes the one-edge-stale and two-edge-fresh readback points exact cycles that the bench can sample. Full-width random masks use all 32 pins, so the set, clear and load paths are driven with dense, sparse, zero and all-ones patterns. Pins are also read back while they are set as outputs.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;

    // Register word selected by the bus address
    typedef enum logic [2:0] {
        SEL_DIR  = 3'd0,
        SEL_OUT  = 3'd1,
        SEL_SET  = 3'd2,
        SEL_CLR  = 3'd3,
        SEL_IN   = 3'd4,
        SEL_NONE = 3'd7
    } reg_sel_e;

    localparam int unsigned NUM_WORDS = 5;

    // Map a word index to a register select
    function automatic reg_sel_e word_to_sel(input int unsigned idx);
        reg_sel_e s;
        case (idx)
            0:       s = SEL_DIR;
            1:       s = SEL_OUT;
            2:       s = SEL_SET;
            3:       s = SEL_CLR;
            4:       s = SEL_IN;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_regbank_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] word_idx;
    logic             aligned;

    always_comb begin
        word_idx = addr[ADDR_W-1:2];
        aligned  = (addr[1:0] == 2'b00);
        sel      = aligned ? word_to_sel(int'(word_idx)) : SEL_NONE;
    end
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
    import gpio_regbank_pkg::*;
#(
    parameter int unsigned PIN_W   = 32,
    parameter logic [PIN_W-1:0] DIR_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  reg_sel_e         sel,
    input  logic [PIN_W-1:0] wdata,
    output logic [PIN_W-1:0] dir_q,
    output logic [PIN_W-1:0] lat_q
);
    typedef struct packed {
        logic [PIN_W-1:0] dir;
        logic [PIN_W-1:0] lat;
    } ctrl_t;

    ctrl_t            st_d, st_q;
    logic [PIN_W-1:0] set_m, clr_m;
    logic             strobe;

    always_comb begin
        st_d   = st_q;
        set_m  = '0;
        clr_m  = '0;
        strobe = 1'b0;
        if (we) begin
            case (sel)
                SEL_DIR: st_d.dir = wdata;
                SEL_OUT: st_d.lat = wdata;
                SEL_SET: begin set_m = wdata; strobe = 1'b1; end
                SEL_CLR: begin clr_m = wdata; strobe = 1'b1; end
                default: ;
            endcase
        end
        // clear wins over set on the same bit
        if (strobe)
            st_d.lat = (st_q.lat | set_m) & ~clr_m;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dir <= DIR_RST;
            st_q.lat <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dir_q = st_q.dir;
    assign lat_q = st_q.lat;

    // R4: marked bits go high, others keep
    p_set_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_SET) |=>
            (((lat_q & $past(wdata)) == $past(wdata)) &&
             ((lat_q & ~$past(wdata)) == ($past(lat_q) & ~$past(wdata)))));

    // R5: marked bits go low, others keep
    p_clr_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_CLR) |=>
            (((lat_q & $past(wdata)) == '0) &&
             ((lat_q & ~$past(wdata)) == ($past(lat_q) & ~$past(wdata)))));

    // R2: direction only moves on its own write
    p_dir_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && sel == SEL_DIR) |=> $stable(dir_q));

    // R9: direction writes leave the latch alone
    p_lat_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_DIR) |=> $stable(lat_q));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned PIN_W  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_W-1:0] pin_in,
    output logic [PIN_W-1:0] sync_out
);
    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][PIN_W-1:0] stg;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.stg[0] = pin_in;
        for (int i = 1; i < STAGES; i++)
            st_d.stg[i] = st_q.stg[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.stg[LAST];

    // R7: the first stage captures the pad level on each edge
    p_first_stage_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(pin_in) |=> (st_q.stg[0] == $past(pin_in)));
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
    import gpio_regbank_pkg::*;
#(
    parameter int unsigned PIN_W = 32
) (
    input  reg_sel_e         sel,
    input  logic [PIN_W-1:0] dir_q,
    input  logic [PIN_W-1:0] lat_q,
    input  logic [PIN_W-1:0] sync_in,
    output logic [PIN_W-1:0] rdata
);
    always_comb begin
        case (sel)
            SEL_DIR:                   rdata = dir_q;
            SEL_OUT, SEL_SET, SEL_CLR: rdata = lat_q;
            SEL_IN:                    rdata = sync_in;
            default:                   rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
    import gpio_regbank_pkg::*;
#(
    parameter int unsigned PIN_W       = 32,
    parameter int unsigned ADDR_W      = 5,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [PIN_W-1:0]  bus_wdata,
    output logic [PIN_W-1:0]  bus_rdata,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_oe,
    output logic [PIN_W-1:0]  pin_out
);
    reg_sel_e         sel;
    logic [PIN_W-1:0] dir_q, lat_q, sync_q;

    gpio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    gpio_ctrl_regs #(.PIN_W(PIN_W), .DIR_RST('1)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_we),
        .sel   (sel),
        .wdata (bus_wdata),
        .dir_q (dir_q),
        .lat_q (lat_q)
    );

    gpio_in_sync #(.PIN_W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .sync_out (sync_q)
    );

    gpio_rd_mux #(.PIN_W(PIN_W)) u_mux (
        .sel     (sel),
        .dir_q   (dir_q),
        .lat_q   (lat_q),
        .sync_in (sync_q),
        .rdata   (bus_rdata)
    );

    assign pin_oe  = ~dir_q;
    assign pin_out = lat_q;

    // R2: output enable is the inverse of the written direction
    p_dir_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel == SEL_DIR) |=> (pin_oe == ~$past(bus_wdata)));

    // R3: load of the whole latch
    p_out_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel == SEL_OUT) |=> (pin_out == $past(bus_wdata)));

    // R6: strobe offsets read back the latch
    p_strobe_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_SET || sel == SEL_CLR) |-> (bus_rdata == pin_out));

    // R7: input word is read-only
    p_in_readonly_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel == SEL_IN) |=> ($stable(pin_out) && $stable(pin_oe)));

    // R8: unmapped writes leave the pins alone
    p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel == SEL_NONE) |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

// File: tb/sim_gpio_regbank.sv
module sim_gpio_regbank;
    localparam int unsigned PW = 32;
    localparam int unsigned AW = 5;
    localparam logic [AW-1:0] A_DIR = 5'h00;
    localparam logic [AW-1:0] A_OUT = 5'h04;
    localparam logic [AW-1:0] A_SET = 5'h08;
    localparam logic [AW-1:0] A_CLR = 5'h0C;
    localparam logic [AW-1:0] A_IN  = 5'h10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [PW-1:0] bus_wdata = '0;
    logic [PW-1:0] bus_rdata;
    logic [PW-1:0] pin_in = '0;
    logic [PW-1:0] pin_oe, pin_out;

    int n_cmp = 0;
    int n_bad = 0;

    // bench model
    logic [PW-1:0] m_dir, m_lat, m_pin;

    always #5 clk = ~clk;

    gpio_regbank #(.PIN_W(PW), .ADDR_W(AW), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out)
    );

    function automatic logic [PW-1:0] exp_read(input logic [AW-1:0] a);
        case (a)
            A_DIR:               return m_dir;
            A_OUT, A_SET, A_CLR: return m_lat;
            A_IN:                return m_pin;
            default:             return '0;
        endcase
    endfunction

    function automatic void model_write(input logic [AW-1:0] a, input logic [PW-1:0] d);
        case (a)
            A_DIR: m_dir = d;
            A_OUT: m_lat = d;
            A_SET: m_lat = m_lat | d;
            A_CLR: m_lat = m_lat & ~d;
            default: ;
        endcase
    endfunction

    task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one bus write; pad level changes on the same negedge
    task automatic wr(input logic [AW-1:0] a, input logic [PW-1:0] d, input logic [PW-1:0] pins);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1; pin_in = pins;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [PW-1:0] d);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [PW-1:0] r;
        logic [PW-1:0] np;
        logic [AW-1:0] a;
        logic [PW-1:0] d;
        int unsigned seed;
        seed = $urandom(32'h5EED_0042);
        m_dir = '1; m_lat = '0; m_pin = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1;
        check("R1 oe", pin_oe, '0);
        check("R1 out", pin_out, '0);
        rd(A_DIR, r); check("R1 dir read", r, '1);
        rd(A_IN, r);  check("R1 in read", r, '0);

        // R2 direction, R9 latch survives
        wr(A_OUT, 32'hA5A5_0F0F, m_pin); model_write(A_OUT, 32'hA5A5_0F0F);
        check("R9 out while input", pin_out, m_lat);
        wr(A_DIR, 32'h0000_FFFF, m_pin); model_write(A_DIR, 32'h0000_FFFF);
        check("R2 oe", pin_oe, 32'hFFFF_0000);
        check("R9 latch kept", pin_out, 32'hA5A5_0F0F);
        rd(A_DIR, r); check("R2 dir read", r, 32'h0000_FFFF);

        // R4 zero mask, full mask
        wr(A_SET, '0, m_pin); model_write(A_SET, '0);
        check("R4 zero mask", pin_out, 32'hA5A5_0F0F);
        wr(A_SET, 32'h0000_00F0, m_pin); model_write(A_SET, 32'h0000_00F0);
        check("R4 set", pin_out, 32'hA5A5_0FFF);
        // R5 clear all
        wr(A_CLR, 32'hFFFF_FFFF, m_pin); model_write(A_CLR, '1);
        check("R5 clear all", pin_out, '0);
        rd(A_CLR, r); check("R6 clr read", r, '0);

        // R7 latency while pins are outputs
        wr(A_DIR, '0, m_pin); model_write(A_DIR, '0);
        @(negedge clk);
        pin_in = 32'hDEAD_BEEF; bus_addr = A_IN;
        @(negedge clk); #1;
        check("R7 one edge stale", bus_rdata, '0);
        @(negedge clk); #1;
        check("R7 two edges fresh", bus_rdata, 32'hDEAD_BEEF);
        m_pin = 32'hDEAD_BEEF;
        wr(A_IN, 32'h1234_5678, m_pin);
        check("R7 write ignored oe", pin_oe, '1);
        check("R7 write ignored out", pin_out, '0);
        rd(A_IN, r); check("R7 in read", r, 32'hDEAD_BEEF);

        // R8 unmapped and misaligned
        wr(5'h14, 32'hFFFF_FFFF, m_pin);
        wr(5'h05, 32'hFFFF_FFFF, m_pin);
        check("R8 out kept", pin_out, '0);
        check("R8 oe kept", pin_oe, '1);
        rd(5'h18, r); check("R8 unmapped read", r, '0);
        rd(5'h05, r); check("R8 misaligned read", r, '0);
        rd(5'h1C, r); check("R8 top read", r, '0);

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom_range(0, 7));
            case (op)
                0: a = A_DIR; 1: a = A_OUT; 2: a = A_SET; 3: a = A_CLR;
                4: a = A_IN;  5: a = 5'h14; 6: a = 5'h1A;
                default: a = 5'h1C;
            endcase
            case ($urandom_range(0, 3))
                0: d = $urandom();
                1: d = $urandom() & $urandom() & $urandom();
                2: d = 32'h1 << $urandom_range(0, 31);
                default: d = ($urandom_range(0, 1) != 0) ? '1 : '0;
            endcase
            np = ($urandom_range(0, 1) != 0) ? $urandom() : m_pin;
            wr(a, d, np);
            model_write(a, d);
            m_pin = np;
            check("R2 oe random", pin_oe, ~m_dir);
            case (a)
                A_SET:   check("R4 set random", pin_out, m_lat);
                A_CLR:   check("R5 clr random", pin_out, m_lat);
                A_OUT:   check("R3 load random", pin_out, m_lat);
                default: check("R8 R9 out random", pin_out, m_lat);
            endcase
            rd(A_IN, r);  check("R7 in random", r, exp_read(A_IN));
            rd(A_SET, r); check("R6 set read", r, exp_read(A_SET));
            rd(A_CLR, r); check("R6 clr read", r, exp_read(A_CLR));
            rd(A_OUT, r); check("R3 out read", r, exp_read(A_OUT));
            rd(A_DIR, r); check("R2 dir read", r, exp_read(A_DIR));
            rd(5'($urandom_range(20, 31)), r); check("R8 read random", r, '0);
        end

        summary();
    end
endmodule